// File: doc/BRIEF.md
# Write-Masked Configuration Register File

This block holds the 256-byte configuration space of a single bus device. Software-style accesses arrive as byte-addressed writes and reads of 1, 2 or 4 bytes. Every byte carries a fixed write mask, so a write changes only the bits that the device allows software to change. Identification values (vendor, device, revision, class, interrupt pin) are set by parameters and cannot be overwritten.

Besides storage, the block interprets the base-address registers. Each implemented base register has a power-of-two window size and a space type (I/O or memory), both fixed by parameters. The write mask of a base register is derived from its size, so writing all ones and reading back reveals the size. From the command byte and the base register contents the block works out, for every window, whether it is currently decoded and at which base. A presented probe address is compared against every decoded window to give a per-window hit.

The window state sits in registers that are refreshed from the configuration bytes on every clock, so any change of a base register, the expansion-ROM register or the enable bits is reflected one cycle after the write lands.

Top module: `cfg_space`

## Requirements
- R1: A write to a byte stores (old AND NOT mask) OR (new AND mask). Fully writable bytes are offset 0x0C, offset 0x3C and every byte from 0x40 to 0xFF; at offset 0x04 only bits 0 (I/O enable), 1 (memory enable) and 2 (bus master) are writable; byte 0x05 and all bytes not named here or in R5/R6 are read-only.
- R2: Access length is encoded as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A multi-byte write puts wr_data[7:0] at wr_addr, the next byte at wr_addr+1 and so on; bytes that would fall past offset 0xFF are dropped.
- R3: A read returns byte rd_addr in rd_data[7:0] and higher addresses in higher bytes (little-endian); lanes beyond the requested length, or past offset 0xFF, read as zero. Reads are combinational.
- R4: Vendor ID (0x00-0x01), device ID (0x02-0x03), revision (0x08), class code (0x09-0x0B) and interrupt pin (0x3D) hold their parameter values and ignore writes.
- R5: Base register n sits at 0x10+4n (n = 0..NUM_BARS-1). With size S it has write mask NOT(S-1); bit 0 reads 1 for an I/O window and 0 for memory and is never writable, so writing 0xFFFFFFFF reads back NOT(S-1) OR type. A base register of size 0 reads zero and ignores writes.
- R6: The expansion-ROM base register is at 0x30; its bit 0 (enable) is writable in addition to NOT(S-1), and its window decodes only while that bit is 1.
- R7: An I/O window is valid only when command bit 0 is 1, the masked base is non-zero, base+S-1 does not wrap and base+S-1 is below 0x10000.
- R8: A memory window is valid only when command bit 1 is 1, the masked base is non-zero, base+S-1 does not wrap and base+S-1 is not 0xFFFFFFFF.
- R9: Reset clears the command byte, offsets 0x0C and 0x3C and the bytes 0x40-0xFF, sets every implemented base register to its type bit alone, and leaves every window invalid.
- R10: Window valid and base outputs reflect the configuration bytes as they stood at the previous clock edge, so a write becomes visible on them one cycle after it lands in the register file.
- R11: win_hit[n] is 1 exactly when window n is valid, probe_io equals the window's space (1 = I/O), and probe_addr AND NOT(S-1) equals the window base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte offset of the first written byte |
| wr_len | input | 2 | Write length code (R2) |
| wr_data | input | 32 | Write data, lowest byte first |
| rd_addr | input | 8 | Byte offset of the first read byte |
| rd_len | input | 2 | Read length code (R2) |
| rd_data | output | 32 | Read data, little-endian |
| probe_addr | input | 32 | Address compared against decoded windows |
| probe_io | input | 1 | 1 when the probe is an I/O address |
| win_valid | output | NUM_BARS+1 | Per-window decode valid; top bit is the ROM window |
| win_base | output | 32*(NUM_BARS+1) | Per-window masked base, window n at bits 32n+31:32n |
| win_hit | output | NUM_BARS+1 | Per-window probe hit |

## Verification
The hardest states to reach from the ports are the window rejection edges: a base register whose last address lands exactly on 0xFFFF (still valid for I/O) or on 0x10000, a memory window ending at 0xFFFFFFFF, which is exactly what the all-ones sizing write produces, and a ROM window whose address is set but whose enable bit is clear. Random writes biased toward the header region with random enable bits cover the general merge rules, while directed writes place bases on each of these boundaries and toggle the enables. A write that straddles offset 0xFF checks truncation, and the one-cycle lag of the window outputs is sampled both before and after the following edge.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int CFG_BYTES  = 256;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / BYTE_W;

    // Byte offsets whose position the decode logic depends on
    localparam int OFF_VENDOR  = 'h00;
    localparam int OFF_DEVICE  = 'h02;
    localparam int OFF_CMD     = 'h04;
    localparam int OFF_REV     = 'h08;
    localparam int OFF_CLASS   = 'h09;
    localparam int OFF_CLINE   = 'h0C;
    localparam int OFF_BAR0    = 'h10;
    localparam int OFF_ROM     = 'h30;
    localparam int OFF_INTLINE = 'h3C;
    localparam int OFF_INTPIN  = 'h3D;
    localparam int OFF_DEVSPEC = 'h40;

    localparam logic [7:0]  CMD_WMASK   = 8'h07;
    localparam int          CMD_IO_BIT  = 0;
    localparam int          CMD_MEM_BIT = 1;
    localparam logic [32:0] IO_LIMIT    = 33'h0_0001_0000;

    typedef enum logic [1:0] {
        LEN_BYTE  = 2'b00,
        LEN_HALF  = 2'b01,
        LEN_WORD  = 2'b10,
        LEN_WORDX = 2'b11
    } acc_len_e;

    typedef struct packed {
        logic                valid;
        logic [WORD_W-1:0]   base;
    } window_t;

    function automatic logic [2:0] len_bytes(input acc_len_e len);
        case (len)
            LEN_BYTE: return 3'd1;
            LEN_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // Decode decision for one window from its raw register contents
    function automatic window_t eval_window(
        input logic [WORD_W-1:0] raw,
        input logic [WORD_W-1:0] size,
        input logic              is_io,
        input logic              is_rom,
        input logic              io_en,
        input logic              mem_en
    );
        window_t        w;
        logic [WORD_W:0] last;
        logic           en;
        logic           span_ok;
        w.base  = raw & ~(size - 32'd1);
        last    = {1'b0, w.base} + {1'b0, size} - 33'd1;
        span_ok = (size != '0) && (w.base != '0) && !last[WORD_W] &&
                  (last[WORD_W-1:0] > w.base);
        if (is_io) begin
            en      = io_en;
            span_ok = span_ok && (last < IO_LIMIT);
        end else begin
            en      = mem_en && (!is_rom || raw[0]);
            span_ok = span_ok && (last[WORD_W-1:0] != 32'hFFFF_FFFF);
        end
        w.valid = en && span_ok;
        return w;
    endfunction

endpackage

// File: rtl/cfg_layout.sv
module cfg_layout
    import cfg_pkg::*;
#(
    parameter int                      NUM_BARS   = 6,
    parameter logic [32*(NUM_BARS+1)-1:0] BAR_SIZE = '0,
    parameter logic [NUM_BARS:0]       BAR_IO     = '0,
    parameter logic [15:0]             VENDOR_ID  = 16'h0000,
    parameter logic [15:0]             DEVICE_ID  = 16'h0000,
    parameter logic [7:0]              REVISION   = 8'h00,
    parameter logic [23:0]             CLASS_CODE = 24'h000000,
    parameter logic [7:0]              INT_PIN    = 8'h00
) (
    output logic [CFG_BYTES*BYTE_W-1:0] wmask_flat,
    output logic [CFG_BYTES*BYTE_W-1:0] rstval_flat
);

    localparam int ROM_SLOT = NUM_BARS;

    function automatic int slot_of(input int idx);
        if (idx >= OFF_BAR0 && idx < OFF_BAR0 + LANES*NUM_BARS)
            return (idx - OFF_BAR0) / LANES;
        if (idx >= OFF_ROM && idx < OFF_ROM + LANES)
            return ROM_SLOT;
        return -1;
    endfunction

    function automatic logic [31:0] slot_size(input int slot);
        return BAR_SIZE[32*slot +: 32];
    endfunction

    function automatic logic [31:0] slot_type(input int slot);
        if (slot == ROM_SLOT || slot_size(slot) == '0) return 32'h0;
        return BAR_IO[slot] ? 32'h1 : 32'h0;
    endfunction

    function automatic logic [31:0] slot_mask(input int slot);
        if (slot_size(slot) == '0) return 32'h0;
        if (slot == ROM_SLOT) return ~(slot_size(slot) - 32'd1) | 32'h1;
        return ~(slot_size(slot) - 32'd1) & ~32'h1;
    endfunction

    function automatic logic [7:0] byte_mask(input int idx);
        logic [31:0] m;
        int          slot;
        if (idx == OFF_CMD) return CMD_WMASK;
        if (idx == OFF_CLINE || idx == OFF_INTLINE || idx >= OFF_DEVSPEC) return 8'hFF;
        slot = slot_of(idx);
        if (slot < 0) return 8'h00;
        m = slot_mask(slot);
        return m[8*(idx % LANES) +: 8];
    endfunction

    function automatic logic [7:0] byte_reset(input int idx);
        logic [31:0] t;
        int          slot;
        case (idx)
            OFF_VENDOR:     return VENDOR_ID[7:0];
            OFF_VENDOR + 1: return VENDOR_ID[15:8];
            OFF_DEVICE:     return DEVICE_ID[7:0];
            OFF_DEVICE + 1: return DEVICE_ID[15:8];
            OFF_REV:        return REVISION;
            OFF_CLASS:      return CLASS_CODE[7:0];
            OFF_CLASS + 1:  return CLASS_CODE[15:8];
            OFF_CLASS + 2:  return CLASS_CODE[23:16];
            OFF_INTPIN:     return INT_PIN;
            default: begin
                slot = slot_of(idx);
                if (slot < 0) return 8'h00;
                t = slot_type(slot);
                return t[8*(idx % LANES) +: 8];
            end
        endcase
    endfunction

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
        assign wmask_flat[BYTE_W*g +: BYTE_W]  = byte_mask(g);
        assign rstval_flat[BYTE_W*g +: BYTE_W] = byte_reset(g);
    end

endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
    import cfg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_addr,
    input  logic [1:0]                    wr_len,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [CFG_BYTES*BYTE_W-1:0]   wmask_flat,
    input  logic [CFG_BYTES*BYTE_W-1:0]   rstval_flat,
    output logic [CFG_BYTES*BYTE_W-1:0]   cfg_flat
);

    logic [2:0] wr_n;
    assign wr_n = len_bytes(acc_len_e'(wr_len));

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
        logic [8:0]        off;
        logic              sel;
        logic [BYTE_W-1:0] lane;
        logic [BYTE_W-1:0] msk;
        logic [BYTE_W-1:0] q;

        // offset from the first written byte; negative wraps to >= 256
        assign off  = 9'(g) - {1'b0, wr_addr};
        assign sel  = wr_en && (off < {6'd0, wr_n});
        assign lane = wr_data[BYTE_W*off[1:0] +: BYTE_W];
        assign msk  = wmask_flat[BYTE_W*g +: BYTE_W];

        always_ff @(posedge clk) begin
            if (rst)
                q <= rstval_flat[BYTE_W*g +: BYTE_W];
            else if (sel)
                q <= (q & ~msk) | (lane & msk);
        end

        assign cfg_flat[BYTE_W*g +: BYTE_W] = q;
    end

endmodule

// File: rtl/cfg_bar_window.sv
module cfg_bar_window
    import cfg_pkg::*;
#(
    parameter logic [31:0] SIZE   = 32'd0,
    parameter bit          IS_IO  = 1'b0,
    parameter bit          IS_ROM = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] raw,
    input  logic              io_en,
    input  logic              mem_en,
    input  logic [WORD_W-1:0] probe_addr,
    input  logic              probe_io,
    output logic              valid,
    output logic [WORD_W-1:0] base,
    output logic              hit
);

    localparam logic [WORD_W-1:0] ALIGN = ~(SIZE - 32'd1);

    window_t next_w;
    window_t win_q;

    assign next_w = eval_window(raw, SIZE, IS_IO, IS_ROM, io_en, mem_en);

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= next_w;
    end

    assign valid = win_q.valid;
    assign base  = win_q.base;
    assign hit   = win_q.valid && (probe_io == IS_IO) &&
                   ((probe_addr & ALIGN) == win_q.base);

endmodule

// File: rtl/cfg_space.sv
module cfg_space
    import cfg_pkg::*;
#(
    parameter int                         NUM_BARS   = 6,
    parameter logic [32*(NUM_BARS+1)-1:0] BAR_SIZE   =
        {32'd2048, 32'd0, 32'd0, 32'd0, 32'd256, 32'd4096, 32'd32},
    parameter logic [NUM_BARS:0]          BAR_IO     = 7'b000_0001,
    parameter logic [15:0]                VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0]                DEVICE_ID  = 16'h4D21,
    parameter logic [7:0]                 REVISION   = 8'h03,
    parameter logic [23:0]                CLASS_CODE = 24'h028000,
    parameter logic [7:0]                 INT_PIN    = 8'h01
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_addr,
    input  logic [1:0]                   wr_len,
    input  logic [31:0]                  wr_data,
    input  logic [7:0]                   rd_addr,
    input  logic [1:0]                   rd_len,
    output logic [31:0]                  rd_data,
    input  logic [31:0]                  probe_addr,
    input  logic                         probe_io,
    output logic [NUM_BARS:0]            win_valid,
    output logic [32*(NUM_BARS+1)-1:0]   win_base,
    output logic [NUM_BARS:0]            win_hit
);

    localparam int NUM_SLOTS = NUM_BARS + 1;

    logic [CFG_BYTES*BYTE_W-1:0] wmask_flat;
    logic [CFG_BYTES*BYTE_W-1:0] rstval_flat;
    logic [CFG_BYTES*BYTE_W-1:0] cfg_flat;

    cfg_layout #(
        .NUM_BARS   (NUM_BARS),
        .BAR_SIZE   (BAR_SIZE),
        .BAR_IO     (BAR_IO),
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .REVISION   (REVISION),
        .CLASS_CODE (CLASS_CODE),
        .INT_PIN    (INT_PIN)
    ) u_layout (
        .wmask_flat  (wmask_flat),
        .rstval_flat (rstval_flat)
    );

    cfg_byte_store u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_len      (wr_len),
        .wr_data     (wr_data),
        .wmask_flat  (wmask_flat),
        .rstval_flat (rstval_flat),
        .cfg_flat    (cfg_flat)
    );

    // little-endian read, lanes past the length or the space read zero
    logic [2:0] rd_n;
    logic [8:0] rd_idx;
    always_comb begin
        rd_data = '0;
        rd_idx  = '0;
        rd_n    = len_bytes(acc_len_e'(rd_len));
        for (int k = 0; k < LANES; k++) begin
            rd_idx = {1'b0, rd_addr} + 9'(k);
            if (3'(k) < rd_n && !rd_idx[8])
                rd_data[BYTE_W*k +: BYTE_W] = cfg_flat[BYTE_W*rd_idx[7:0] +: BYTE_W];
        end
    end

    logic io_en;
    logic mem_en;
    assign io_en  = cfg_flat[BYTE_W*OFF_CMD + CMD_IO_BIT];
    assign mem_en = cfg_flat[BYTE_W*OFF_CMD + CMD_MEM_BIT];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int  BOFF   = (s == NUM_BARS) ? OFF_ROM : OFF_BAR0 + LANES*s;
        localparam bit  ROM_W  = (s == NUM_BARS);
        localparam bit  IO_W   = BAR_IO[s] && !ROM_W;

        cfg_bar_window #(
            .SIZE   (BAR_SIZE[32*s +: 32]),
            .IS_IO  (IO_W),
            .IS_ROM (ROM_W)
        ) u_win (
            .clk        (clk),
            .rst        (rst),
            .raw        (cfg_flat[BYTE_W*BOFF +: WORD_W]),
            .io_en      (io_en),
            .mem_en     (mem_en),
            .probe_addr (probe_addr),
            .probe_io   (probe_io),
            .valid      (win_valid[s]),
            .base       (win_base[32*s +: 32]),
            .hit        (win_hit[s])
        );
    end

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
    parameter int                NUM_BARS = 6,
    parameter logic [NUM_BARS:0] BAR_IO   = '0
) (
    input logic                        clk,
    input logic                        rst,
    input logic [7:0]                  cmd_byte,
    input logic [7:0]                  cline_byte,
    input logic [7:0]                  intline_byte,
    input logic [31:0]                 id_word,
    input logic                        rom_enable,
    input logic                        probe_io,
    input logic [NUM_BARS:0]           win_valid,
    input logic [32*(NUM_BARS+1)-1:0]  win_base,
    input logic [NUM_BARS:0]           win_hit
);

    // R9: the cycle after reset the enables and windows are clear
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (win_valid == '0 && cmd_byte == 8'h00 &&
                        cline_byte == 8'h00 && intline_byte == 8'h00));

    // R4: identification word never changes outside reset
    assert_id_stable_R4: assert property (@(posedge clk) disable iff (rst)
        $stable(id_word));

    // R1: command bits above bus master are never set
    assert_cmd_ro_R1: assert property (@(posedge clk) disable iff (rst)
        $stable(cmd_byte[7:3]));

    // R6: ROM window needs its enable bit at the previous edge
    assert_rom_enable_R6: assert property (@(posedge clk) disable iff (rst)
        win_valid[NUM_BARS] |-> $past(rom_enable));

    for (genvar s = 0; s <= NUM_BARS; s++) begin : g_chk
        // R7 / R8: a decoded window never has a zero base
        assert_base_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
            win_valid[s] |-> (win_base[32*s +: 32] != 32'h0));

        if (BAR_IO[s] && s != NUM_BARS) begin : g_io
            assert_io_enable_R7: assert property (@(posedge clk) disable iff (rst)
                win_valid[s] |-> $past(cmd_byte[0]));
        end else begin : g_mem
            assert_mem_enable_R8: assert property (@(posedge clk) disable iff (rst)
                win_valid[s] |-> $past(cmd_byte[1]));
        end

        // R11: a hit only ever comes from a valid window of the probed space
        assert_hit_space_R11: assert property (@(posedge clk) disable iff (rst)
            win_hit[s] |-> (win_valid[s] &&
                            probe_io == (BAR_IO[s] && s != NUM_BARS)));
    end

endmodule

bind cfg_space cfg_space_chk #(
    .NUM_BARS (NUM_BARS),
    .BAR_IO   (BAR_IO)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_byte     (cfg_flat[39:32]),
    .cline_byte   (cfg_flat[103:96]),
    .intline_byte (cfg_flat[487:480]),
    .id_word      (cfg_flat[31:0]),
    .rom_enable   (cfg_flat[384]),
    .probe_io     (probe_io),
    .win_valid    (win_valid),
    .win_base     (win_base),
    .win_hit      (win_hit)
);

// File: tb/tb_cfg_space.sv
module tb_cfg_space;

    localparam int NB = 6;
    localparam int NS = NB + 1;
    localparam logic [32*NS-1:0] SIZES =
        {32'd2048, 32'd0, 32'd0, 32'd0, 32'd256, 32'd4096, 32'd32};
    localparam logic [NS-1:0] IOS = 7'b000_0001;
    localparam logic [15:0] VID  = 16'hC0DE;
    localparam logic [15:0] DID  = 16'h4D21;
    localparam logic [7:0]  REV  = 8'h03;
    localparam logic [23:0] CLS  = 24'h028000;
    localparam logic [7:0]  IPIN = 8'h01;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [1:0] wr_len = '0;
    logic [31:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [1:0] rd_len = '0;
    logic [31:0] rd_data;
    logic [31:0] probe_addr = '0;
    logic probe_io = 1'b0;
    logic [NS-1:0] win_valid;
    logic [32*NS-1:0] win_base;
    logic [NS-1:0] win_hit;

    int checks = 0;
    int fails = 0;
    logic [7:0] mdl [256];

    always #2 clk = ~clk;

    cfg_space #(
        .NUM_BARS(NB), .BAR_SIZE(SIZES), .BAR_IO(IOS), .VENDOR_ID(VID),
        .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS), .INT_PIN(IPIN)
    ) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_len(rd_len), .rd_data(rd_data),
        .probe_addr(probe_addr), .probe_io(probe_io), .win_valid(win_valid),
        .win_base(win_base), .win_hit(win_hit)
    );

    function automatic int nbytes(input logic [1:0] len);
        return (len == 2'd0) ? 1 : (len == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] sz(input int s);
        return SIZES[32*s +: 32];
    endfunction

    function automatic logic [7:0] exp_mask(input int a);
        logic [31:0] m;
        int s;
        if (a == 4) return 8'h07;
        if (a == 12 || a == 60 || a >= 64) return 8'hFF;
        if (a >= 16 && a < 16 + 4*NB) begin
            s = (a - 16) / 4;
            m = (sz(s) == 0) ? 32'h0 : (~(sz(s) - 1) & ~32'h1);
            return m[8*(a%4) +: 8];
        end
        if (a >= 48 && a < 52) begin
            m = ~(sz(NB) - 1) | 32'h1;
            return m[8*(a%4) +: 8];
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_rst(input int a);
        case (a)
            0: return VID[7:0];
            1: return VID[15:8];
            2: return DID[7:0];
            3: return DID[15:8];
            8: return REV;
            9: return CLS[7:0];
            10: return CLS[15:8];
            11: return CLS[23:16];
            61: return IPIN;
            16: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 256; a++) mdl[a] = exp_rst(a);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [1:0] l, input logic [31:0] d);
        int ad;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_len = l; wr_data = d;
        for (int k = 0; k < nbytes(l); k++) begin
            ad = int'(a) + k;
            if (ad < 256)
                mdl[ad] = (mdl[ad] & ~exp_mask(ad)) | (d[8*k +: 8] & exp_mask(ad));
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [1:0] l);
        logic [31:0] v = '0;
        int ad;
        for (int k = 0; k < nbytes(l); k++) begin
            ad = int'(a) + k;
            if (ad < 256) v[8*k +: 8] = mdl[ad];
        end
        return v;
    endfunction

    task automatic check_read(input logic [7:0] a, input logic [1:0] l, input string tag);
        logic [31:0] e;
        rd_addr = a; rd_len = l;
        #1;
        e = exp_read(a, l);
        check(rd_data === e, tag, rd_data, e);
    endtask

    task automatic exp_win(input int s, output logic v, output logic [31:0] b);
        logic [31:0] raw;
        logic [32:0] last;
        int off;
        off = (s == NB) ? 'h30 : 'h10 + 4*s;
        raw = {mdl[off+3], mdl[off+2], mdl[off+1], mdl[off]};
        b = raw & ~(sz(s) - 1);
        last = {1'b0, b} + {1'b0, sz(s)} - 33'd1;
        v = 1'b0;
        if (sz(s) != 0 && b != 0 && !last[32] && last[31:0] > b) begin
            if (IOS[s] && s != NB) v = mdl[4][0] && (last < 33'h10000);
            else v = mdl[4][1] && (last[31:0] != 32'hFFFF_FFFF) && (s != NB || raw[0]);
        end
    endtask

    task automatic check_windows(input string tag);
        logic v;
        logic [31:0] b;
        for (int s = 0; s < NS; s++) begin
            exp_win(s, v, b);
            check(win_valid[s] === v, tag, {31'd0, win_valid[s]}, {31'd0, v});
            if (v) check(win_base[32*s +: 32] === b, tag, win_base[32*s +: 32], b);
        end
    endtask

    task automatic check_hit(input logic [31:0] pa, input logic pio, input int s,
                             input logic e, input string tag);
        probe_addr = pa; probe_io = pio;
        #1;
        check(win_hit[s] === e, tag, {31'd0, win_hit[s]}, {31'd0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [7:0] a;
        logic [1:0] l;
        logic [31:0] d;
        unused_seed = $urandom(32'h5EED);
        model_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 / R4 reset state
        check_read(8'h00, 2'd2, "R4 id after reset");
        check_read(8'h08, 2'd2, "R4 revision/class");
        check_read(8'h3C, 2'd1, "R4 int pin");
        check_read(8'h10, 2'd2, "R9 bar0 type only");
        check_read(8'h04, 2'd1, "R9 command clear");
        check_windows("R9 windows invalid");

        // R5 sizing by all ones
        do_write(8'h10, 2'd2, 32'hFFFF_FFFF);
        check_read(8'h10, 2'd2, "R5 io sizing");
        check(rd_data === 32'hFFFF_FFE1, "R5 io sizing value", rd_data, 32'hFFFF_FFE1);
        do_write(8'h14, 2'd3, 32'hFFFF_FFFF);
        check_read(8'h14, 2'd2, "R5 mem sizing");
        check(rd_data === 32'hFFFF_F000, "R5 mem sizing value", rd_data, 32'hFFFF_F000);
        do_write(8'h1C, 2'd2, 32'h1234_5678);
        check_read(8'h1C, 2'd2, "R5 unimplemented bar");
        check(rd_data === 32'h0, "R5 unimplemented zero", rd_data, 32'h0);

        // R8 sizing pattern with memory enabled ends at 0xFFFFFFFF: rejected
        do_write(8'h04, 2'd1, 32'h0000_FFFF);
        check_read(8'h04, 2'd1, "R1 command mask");
        check(rd_data === 32'h0000_0007, "R1 command value", rd_data, 32'h7);
        @(negedge clk);
        check_windows("R8 top-of-space rejected");

        // R4 writes to identification ignored
        do_write(8'h00, 2'd2, 32'h0000_0000);
        do_write(8'h08, 2'd2, 32'hFFFF_FFFF);
        do_write(8'h3D, 2'd0, 32'h0000_00AA);
        check_read(8'h00, 2'd2, "R4 id ignores writes");
        check_read(8'h08, 2'd2, "R4 class ignores writes");
        check_read(8'h3C, 2'd1, "R4 pin ignores writes");

        // R7 / R10 / R11 I/O window
        do_write(8'h10, 2'd2, 32'h0000_0000);
        @(negedge clk);
        check_windows("R7 zero base rejected");
        do_write(8'h10, 2'd2, 32'h0000_2000);
        check(win_valid[0] === 1'b0, "R10 window lags write", {31'd0, win_valid[0]}, 32'd0);
        @(negedge clk);
        check(win_valid[0] === 1'b1, "R10 window after one cycle", {31'd0, win_valid[0]}, 32'd1);
        check_windows("R7 io window");
        check_hit(32'h0000_201F, 1'b1, 0, 1'b1, "R11 io hit top");
        check_hit(32'h0000_2020, 1'b1, 0, 1'b0, "R11 io miss past end");
        check_hit(32'h0000_2000, 1'b0, 0, 1'b0, "R11 io space mismatch");
        do_write(8'h10, 2'd2, 32'h0000_FFE0);
        @(negedge clk);
        check_windows("R7 io last 0xFFFF valid");
        do_write(8'h10, 2'd2, 32'h0001_0000);
        @(negedge clk);
        check_windows("R7 io above 64K rejected");
        do_write(8'h04, 2'd0, 32'h0000_0002);
        do_write(8'h10, 2'd2, 32'h0000_3000);
        @(negedge clk);
        check_windows("R7 io enable off");

        // R8 memory windows
        do_write(8'h14, 2'd2, 32'h8000_0000);
        do_write(8'h18, 2'd2, 32'hFFFF_FE00);
        @(negedge clk);
        check_windows("R8 mem windows");
        check_hit(32'h8000_0FFF, 1'b0, 1, 1'b1, "R11 mem hit");
        check_hit(32'h8000_1000, 1'b0, 1, 1'b0, "R11 mem miss");
        do_write(8'h04, 2'd0, 32'h0000_0000);
        @(negedge clk);
        check_windows("R8 mem enable off");
        do_write(8'h04, 2'd0, 32'h0000_0003);

        // R6 ROM window
        do_write(8'h30, 2'd2, 32'h000C_0000);
        @(negedge clk);
        check_windows("R6 rom disabled");
        check(win_valid[NB] === 1'b0, "R6 rom off", {31'd0, win_valid[NB]}, 32'd0);
        do_write(8'h30, 2'd0, 32'h0000_0001);
        @(negedge clk);
        check_windows("R6 rom enabled");
        check_read(8'h30, 2'd2, "R6 rom readback");

        // R2 / R3 truncation at the end of the space
        do_write(8'hFE, 2'd2, 32'hDDCC_BBAA);
        check_read(8'hFE, 2'd2, "R2 write truncated");
        check_read(8'hFF, 2'd1, "R3 read truncated");
        check_read(8'hFD, 2'd3, "R3 length code 3");
        do_write(8'h0B, 2'd2, 32'h4433_2211);
        check_read(8'h0C, 2'd0, "R2 byte order");
        check(rd_data === 32'h22, "R2 byte order value", rd_data, 32'h22);

        // random mix, R1 / R3 / R7 / R8
        for (int i = 0; i < 400; i++) begin
            a = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 64);
            l = 2'($urandom);
            d = ($urandom % 2 == 0) ? $urandom : ($urandom & 32'h0003_FFFF);
            do_write(a, l, d);
            check_read(8'($urandom % 256), 2'($urandom), "R1 random merge");
            check_read(a, l, "R3 random readback");
            @(negedge clk);
            check_windows("R7 R8 random windows");
        end

        // R9 reset restores defaults
        do_write(8'h40, 2'd2, 32'h5A5A_5A5A);
        do_write(8'h0C, 2'd0, 32'h0000_0010);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_read(8'h04, 2'd1, "R9 command after reset");
        check_read(8'h0C, 2'd0, "R9 cache line after reset");
        check_read(8'h3C, 2'd0, "R9 int line after reset");
        check_read(8'h40, 2'd2, "R9 device bytes after reset");
        check_read(8'h10, 2'd2, "R9 bar types after reset");
        check_read(8'h30, 2'd2, "R9 rom after reset");
        @(negedge clk);
        check_windows("R9 windows after reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule